// File: doc/BRIEF.md
# Three-Common Multiplexed LCD Sequencer

This block turns a latched image of display bits into the level selections for a 1/3-duty passive LCD panel. The panel has three common lines and up to twenty-five segment lines. Each output is a 2-bit code that selects one of four analog rails. The rails, the divider that makes them and the pad drivers sit outside the block. Time advances on a base clock enable, and each common line is active in turn. The drive polarity reverses on every other frame, so the panel never sees a net DC voltage.

Control inputs pick the bias scheme and blank the panel. Blanking drives the segment-off waveform, so the commons keep running. A sleep input darkens and freezes the panel. A 3-bit port select turns the lowest segment pins, counting upward from pin 0, into static outputs. Each static output follows one display bit. The static outputs keep working in sleep.

Top module: `lcd3_mux_driver`

## Requirements
- R1: While rst_n is low, every code on seg_lvl and com_lvl is 0, whatever port_sel and disp_bits hold. After release, the timing restarts from the first frame with common 0 active.
- R2: Each clock edge on which tick_en is 1 and sleep is 0 counts as one tick. Common j is active for 128 consecutive ticks, in the order 0, 1, 2, so one frame is 384 ticks. At any time exactly one common drives a full-swing code (0 or 3).
- R3: The frame polarity starts at 0 after reset and flips after every frame. With polarity 0 the active common drives 3; with polarity 1 it drives 0.
- R4: With bias_half=0 (one-third bias), each inactive common drives 1 under polarity 0 and 2 under polarity 1. A lit segment drives 0 or 3, the opposite rail from the active common. An unlit segment drives 2 under polarity 0 and 1 under polarity 1.
- R5: With bias_half=1 (half bias), every inactive common and every unlit segment drives the mid code 2. Code 1 never appears on a common.
- R6: Segment pin k, while common c is active, is lit when disp_bits[3k+c] is 1.
- R7: With blank=1, every segment pin outside port mode drives the unlit code for the current polarity and bias. The commons keep sequencing.
- R8: With sleep=1, all common codes and all segment codes outside port mode are 0 and the timing does not advance. When sleep returns to 0, timing resumes from where it stopped.
- R9: A port_sel value v puts pins 0..v-1 into port mode. Values from 4 to 7 put all four low pins into port mode.
- R10: A pin k in port mode drives 3 when disp_bits[3k] is 1 and 0 when it is 0. Bias, blank, polarity and sleep have no effect on it.
- R11: On an edge with tick_en=0 the active common and the polarity do not change.
- R12: The outputs are registered. The codes seen after a clock edge reflect the inputs and the timing state present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base oscillator tick enable |
| disp_bits | input | 75 | Display image, three bits per segment pin |
| bias_half | input | 1 | 1 selects half bias, 0 selects one-third bias |
| blank | input | 1 | 1 drives segment-off waveforms |
| port_sel | input | 3 | Number of low pins in static port mode |
| sleep | input | 1 | Darken outputs and freeze timing |
| seg_lvl | output | 50 | Segment rail codes, pin k at bits [2k+1:2k] |
| com_lvl | output | 6 | Common rail codes, common j at bits [2j+1:2j] |

## Verification
The hardest case to reach from the ports is the second-polarity frame combined with gaps in the tick enable and a sleep interval that stops in the middle of a phase. The bench models the elapsed tick count arithmetically and checks both output vectors after every clock. The stimulus runs past the frame boundary and then changes the bias, the blanking and each port select value, including the saturating values. It also freezes the timing partway through a phase and later resumes it, so that both polarities and every common phase are reached under each mode.

// File: rtl/lcd3_pkg.sv
package lcd3_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND = 2'd0;
  localparam lvl_t LVL_LO  = 2'd1;
  localparam lvl_t LVL_HI  = 2'd2;
  localparam lvl_t LVL_TOP = 2'd3;

  // level of one common line: sel marks the active phase
  function automatic lvl_t com_level(input logic sel, input logic pol, input logic half);
    lvl_t r;
    if (sel)       r = pol ? LVL_GND : LVL_TOP;
    else if (half) r = LVL_HI;
    else           r = pol ? LVL_HI : LVL_LO;
    return r;
  endfunction

  // level of one segment line: lit drives the rail opposite the active common
  function automatic lvl_t seg_level(input logic lit, input logic pol, input logic half);
    lvl_t r;
    if (lit)       r = pol ? LVL_TOP : LVL_GND;
    else if (half) r = LVL_HI;
    else           r = pol ? LVL_LO : LVL_HI;
    return r;
  endfunction

endpackage

// File: rtl/lcd3_timebase.sv
module lcd3_timebase #(
  parameter int PHASE_TICKS = 128,
  parameter int NCOM        = 3,
  parameter int PW          = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1,
  parameter int CW          = (NCOM > 1) ? $clog2(NCOM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] com_idx,
  output logic          pol
);

  localparam logic [PW-1:0] PH_LAST  = PW'(PHASE_TICKS - 1);
  localparam logic [CW-1:0] COM_LAST = CW'(NCOM - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic [CW-1:0] com_q, com_d;
  logic          pol_q, pol_d;

  always_comb begin
    phase_d = phase_q;
    com_d   = com_q;
    pol_d   = pol_q;
    if (adv) begin
      if (phase_q == PH_LAST) begin
        phase_d = '0;
        if (com_q == COM_LAST) begin
          com_d = '0;
          pol_d = ~pol_q;
        end else begin
          com_d = com_q + CW'(1);
        end
      end else begin
        phase_d = phase_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      com_q   <= '0;
      pol_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      com_q   <= com_d;
      pol_q   <= pol_d;
    end
  end

  assign com_idx = com_q;
  assign pol     = pol_q;

endmodule

// File: rtl/lcd3_port_map.sv
module lcd3_port_map #(
  parameter int NPORT = 4,
  parameter int SELW  = 3
) (
  input  logic [SELW-1:0]  port_sel,
  output logic [NPORT-1:0] port_mask
);

  // thermometer code: pin i is a port when the count exceeds i
  for (genvar i = 0; i < NPORT; i++) begin : g_bit
    assign port_mask[i] = (port_sel > SELW'(i));
  end

endmodule

// File: rtl/lcd3_seg_gen.sv
module lcd3_seg_gen
  import lcd3_pkg::*;
#(
  parameter int NSEG  = 25,
  parameter int NCOM  = 3,
  parameter int NPORT = 4,
  parameter int CW    = 2
) (
  input  logic [NSEG*NCOM-1:0] disp,
  input  logic [CW-1:0]        com_idx,
  input  logic                 pol,
  input  logic                 half,
  input  logic                 blank,
  input  logic                 sleep,
  input  logic [NPORT-1:0]     port_mask,
  output logic [2*NSEG-1:0]    seg_lvl
);

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [NCOM-1:0] bits;
    logic            lit;
    lvl_t            drv;

    assign bits = disp[k*NCOM +: NCOM];
    assign lit  = bits[com_idx] & ~blank;

    if (k < NPORT) begin : g_dual
      always_comb begin
        if (port_mask[k])  drv = bits[0] ? LVL_TOP : LVL_GND;
        else if (sleep)    drv = LVL_GND;
        else               drv = seg_level(lit, pol, half);
      end
    end else begin : g_plain
      always_comb begin
        if (sleep) drv = LVL_GND;
        else       drv = seg_level(lit, pol, half);
      end
    end

    assign seg_lvl[2*k +: 2] = drv;
  end

endmodule

// File: rtl/lcd3_mux_driver.sv
module lcd3_mux_driver
  import lcd3_pkg::*;
#(
  parameter int NSEG        = 25,
  parameter int NCOM        = 3,
  parameter int NPORT       = 4,
  parameter int SELW        = 3,
  parameter int PHASE_TICKS = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic [NSEG*NCOM-1:0]   disp_bits,
  input  logic                   bias_half,
  input  logic                   blank,
  input  logic [SELW-1:0]        port_sel,
  input  logic                   sleep,
  output logic [2*NSEG-1:0]      seg_lvl,
  output logic [2*NCOM-1:0]      com_lvl
);

  localparam int CW = (NCOM > 1) ? $clog2(NCOM) : 1;

  logic [CW-1:0]     com_idx;
  logic              pol;
  logic              adv;
  logic [NPORT-1:0]  port_mask;
  logic [2*NSEG-1:0] seg_raw, seg_d, seg_q;
  logic [2*NCOM-1:0] com_raw, com_d, com_q;

  assign adv = tick_en & ~sleep;

  lcd3_timebase #(
    .PHASE_TICKS (PHASE_TICKS),
    .NCOM        (NCOM),
    .CW          (CW)
  ) u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .com_idx (com_idx),
    .pol     (pol)
  );

  lcd3_port_map #(
    .NPORT (NPORT),
    .SELW  (SELW)
  ) u_ports (
    .port_sel  (port_sel),
    .port_mask (port_mask)
  );

  lcd3_seg_gen #(
    .NSEG  (NSEG),
    .NCOM  (NCOM),
    .NPORT (NPORT),
    .CW    (CW)
  ) u_segs (
    .disp      (disp_bits),
    .com_idx   (com_idx),
    .pol       (pol),
    .half      (bias_half),
    .blank     (blank),
    .sleep     (sleep),
    .port_mask (port_mask),
    .seg_lvl   (seg_raw)
  );

  for (genvar j = 0; j < NCOM; j++) begin : g_com
    assign com_raw[2*j +: 2] = sleep ? LVL_GND
                             : com_level(com_idx == CW'(j), pol, bias_half);
  end

  always_comb begin
    seg_d = seg_raw;
    com_d = com_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      com_q <= '0;
    end else begin
      seg_q <= seg_d;
      com_q <= com_d;
    end
  end

  assign seg_lvl = seg_q;
  assign com_lvl = com_q;

endmodule

// File: rtl/lcd3_mux_driver_chk.sv
module lcd3_mux_driver_chk #(
  parameter int NSEG  = 25,
  parameter int NCOM  = 3,
  parameter int NPORT = 4,
  parameter int SELW  = 3,
  parameter int CW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              sleep,
  input logic              bias_half,
  input logic [SELW-1:0]   port_sel,
  input logic              port0_bit,
  input logic [2*NSEG-1:0] seg_lvl,
  input logic [2*NCOM-1:0] com_lvl,
  input logic [CW-1:0]     com_idx,
  input logic              pol
);

  logic [NCOM-1:0] full_swing;
  logic [NCOM-1:0] low_mid;

  for (genvar j = 0; j < NCOM; j++) begin : g_cls
    assign full_swing[j] = (com_lvl[2*j] == com_lvl[2*j+1]);
    assign low_mid[j]    = (com_lvl[2*j +: 2] == 2'd1);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_dark_r1: assert (seg_lvl == '0 && com_lvl == '0)
        else $error("outputs not dark in reset");
    end
  end

  p_com_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (com_idx != $past(com_idx)) |->
      ((int'(com_idx) == int'($past(com_idx)) + 1) ||
       (com_idx == '0 && int'($past(com_idx)) == NCOM - 1)))
    else $error("common order broken");

  p_single_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sleep)) |-> ($countones(full_swing) == 1))
    else $error("not exactly one active common");

  p_pol_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pol != $past(pol)) |-> (com_idx == '0 && int'($past(com_idx)) == NCOM - 1))
    else $error("polarity flipped off a frame edge");

  p_half_no_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bias_half)) |-> (low_mid == '0))
    else $error("code 1 on common in half bias");

  p_sleep_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sleep)) |->
      (com_lvl == '0 && seg_lvl[2*NSEG-1:2*NPORT] == '0))
    else $error("outputs active in sleep");

  p_port_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(port_sel) != '0) |-> (seg_lvl[1:0] == {2{$past(port0_bit)}}))
    else $error("port pin 0 wrong level");

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(com_idx) && $stable(pol)))
    else $error("timing moved without tick");

endmodule

bind lcd3_mux_driver lcd3_mux_driver_chk #(
  .NSEG  (NSEG),
  .NCOM  (NCOM),
  .NPORT (NPORT),
  .SELW  (SELW),
  .CW    (CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .sleep     (sleep),
  .bias_half (bias_half),
  .port_sel  (port_sel),
  .port0_bit (disp_bits[0]),
  .seg_lvl   (seg_lvl),
  .com_lvl   (com_lvl),
  .com_idx   (com_idx),
  .pol       (pol)
);

// File: tb/sim_lcd3_mux_driver.sv
module sim_lcd3_mux_driver;

  localparam int CLK_PERIOD = 10;
  localparam int NS   = 25;
  localparam int NC   = 3;
  localparam int PH   = 128;
  localparam int NB   = NS * NC;

  logic            clk;
  logic            rst_n;
  logic            tick_en;
  logic [NB-1:0]   disp_bits;
  logic            bias_half;
  logic            blank;
  logic [2:0]      port_sel;
  logic            sleep;
  logic [2*NS-1:0] seg_lvl;
  logic [2*NC-1:0] com_lvl;

  int n_chk;
  int n_bad;
  int cnt;
  bit done;

  lcd3_mux_driver u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .disp_bits (disp_bits),
    .bias_half (bias_half),
    .blank     (blank),
    .port_sel  (port_sel),
    .sleep     (sleep),
    .seg_lvl   (seg_lvl),
    .com_lvl   (com_lvl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [NB-1:0] pat(input int p);
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = (((i * 7 + p * 13) % 5) < 2);
    return v;
  endfunction

  // expected codes from the requirements, using the bench tick count
  function automatic void model(output logic [2*NS-1:0] es, output logic [2*NC-1:0] ec);
    int c, pl, pc;
    logic lit;
    es = '0;
    ec = '0;
    if (!rst_n) return;
    c  = (cnt / PH) % NC;
    pl = (cnt / (PH * NC)) % 2;
    pc = (port_sel > 3'd4) ? 4 : int'(port_sel);
    for (int j = 0; j < NC; j++) begin
      if (!sleep) begin
        if (j == c)         ec[2*j +: 2] = (pl == 1) ? 2'd0 : 2'd3;
        else if (bias_half) ec[2*j +: 2] = 2'd2;
        else                ec[2*j +: 2] = (pl == 1) ? 2'd2 : 2'd1;
      end
    end
    for (int k = 0; k < NS; k++) begin
      if (k < pc) begin
        es[2*k +: 2] = disp_bits[3*k] ? 2'd3 : 2'd0;
      end else if (!sleep) begin
        lit = !blank && disp_bits[3*k + c];
        if (lit)            es[2*k +: 2] = (pl == 1) ? 2'd3 : 2'd0;
        else if (bias_half) es[2*k +: 2] = 2'd2;
        else                es[2*k +: 2] = (pl == 1) ? 2'd1 : 2'd2;
      end
    end
  endfunction

  // one clock: predict, advance the tick model, sample at the falling edge (R12)
  task automatic step(input string tag);
    logic [2*NS-1:0] es;
    logic [2*NC-1:0] ec;
    model(es, ec);
    @(posedge clk);
    if (!rst_n) cnt = 0;
    else if (tick_en && !sleep) cnt++;
    @(negedge clk);
    n_chk++;
    if (seg_lvl !== es || com_lvl !== ec) begin
      n_bad++;
      $display("FAIL %s tick=%0d seg=%h exp=%h com=%h exp=%h",
               tag, cnt, seg_lvl, es, com_lvl, ec);
    end
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    n_chk = 0; n_bad = 0; cnt = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b1; bias_half = 1'b0; blank = 1'b0;
    sleep = 1'b0; port_sel = 3'd4; disp_bits = '1;
    @(negedge clk);
    run("R1 reset dark with ports selected", 5);

    rst_n = 1'b1; port_sel = 3'd0; disp_bits = pat(1);
    run("R2 R3 R4 R6 R12 third bias frames", 800);
    for (int p = 2; p < 6; p++) begin
      disp_bits = pat(p);
      run("R6 R4 data pattern", 130);
    end

    bias_half = 1'b1; disp_bits = pat(9);
    run("R5 half bias frames", 800);

    bias_half = 1'b0; blank = 1'b1;
    run("R7 blank third bias", 400);
    bias_half = 1'b1;
    run("R7 blank half bias", 200);
    bias_half = 1'b0; blank = 1'b0;

    for (int s = 0; s < 8; s++) begin
      port_sel = 3'(s);
      disp_bits = pat(s + 11);
      blank = s[0];
      bias_half = s[1];
      run("R9 R10 port select sweep", 60);
      sleep = 1'b1;
      run("R10 R8 port pins during sleep", 10);
      sleep = 1'b0;
    end
    port_sel = 3'd0; blank = 1'b0; bias_half = 1'b0;

    run("R2 realign", 50);
    sleep = 1'b1;
    run("R8 sleep freeze", 150);
    sleep = 1'b0;
    run("R8 resume", 400);

    for (int i = 0; i < 1200; i++) begin
      tick_en = (i % 3 == 0);
      step("R11 tick enable gaps");
    end
    tick_en = 1'b1;

    port_sel = 3'd2;
    rst_n = 1'b0;
    run("R1 reset mid run", 3);
    rst_n = 1'b1;
    run("R1 R2 restart after reset", 400);

    finish_up();
  end

endmodule